// File: doc/BRIEF.md
# Interrupt Acceptance Stage

This block decides when a pending interrupt turns into a trap for an in-order pipeline that issues instructions in groups. The block registers the four-bit external interrupt level and a breakpoint request on a clock edge. In the next cycle it picks one winner and qualifies it against the trap-enable bit and the processor interrupt level. In the cycle after that it posts an exception to whichever instruction group sits in the first execute stage. The strobe fires only when that stage holds a valid instruction, so the interrupted program counter always names a real instruction.

An external interrupt is charged to the youngest valid slot of the execute group. Slot 0 is the oldest and the highest index is the youngest. A breakpoint is charged to the slot that raised it. Requests are not latched. Each cycle the block looks again at the freshly sampled inputs, so a request that goes away before it is accepted is lost. Squashing and handler entry belong to the consumer of the strobe.

Top module: `irq_accept`

## Requirements
- R1: While reset is low, and for the first two cycles after it is released, `exc_strobe` is 0. `exc_slot` and `exc_tt` read 0 whenever `exc_strobe` is 0.
- R2: Inputs present at clock edge k decide the outputs in the cycle that follows edge k+1. That cycle is two edges later, and `e0_valid` in that cycle is the value used.
- R3: When `psr_et` is 0 at the selection edge (edge k+1), no request is selected.
- R4: An external level L (1..14) is selected only when L > `psr_pil`. Level 0 means no request.
- R5: Level 15 is selected whenever `psr_et` is 1, even when `psr_pil` is 15.
- R6: The trap type for an external level L is 0x10 + L. The trap type for a breakpoint is the `BKPT_TT` parameter, 0x0B by default.
- R7: An external interrupt targets the highest-index slot whose `e0_valid` bit is 1.
- R8: A breakpoint request wins over any external level. It targets `bkpt_slot`, and it fires only while that slot's `e0_valid` bit is 1. An out-of-range slot never fires.
- R9: With no valid target in the execute stage, the strobe waits. It fires in the first cycle in which a valid target appears, provided the request is still selected.
- R10: A request is re-evaluated each cycle. A level pulse that drops, or a `psr_pil` rise, before a valid target appears is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irl_pin | input | 4 | External interrupt level, 0 means none |
| bkpt_req | input | 1 | Internal breakpoint request |
| bkpt_slot | input | 2 | Execute-stage slot that raised the breakpoint |
| psr_et | input | 1 | Trap enable |
| psr_pil | input | 4 | Processor interrupt level |
| e0_valid | input | 3 | Per-slot valid bits in the first execute stage |
| exc_strobe | output | 1 | Interrupt exception posted this cycle |
| exc_slot | output | 2 | Slot charged with the exception |
| exc_tt | output | 8 | Trap type |

## Verification
A breakpoint and an external level can be selected in the same cycle. The bench raises both together and expects the breakpoint's slot and trap type, with the external level dropped entirely. The bench also lets a selected request meet an empty or partly valid execute group in the same cycle. For that case the cycle-by-cycle reference model decides whether the strobe is due. When the strobe is due, the model also decides which slot is charged.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int IRQ_SLOTS  = 3;
    parameter int IRQ_SLOT_W = (IRQ_SLOTS > 1) ? $clog2(IRQ_SLOTS) : 1;
    parameter int IRQ_LVL_W  = 4;
    parameter int IRQ_TT_W   = 8;
    localparam logic [IRQ_LVL_W-1:0] IRQ_NMI = '1;
    localparam logic [IRQ_TT_W-1:0]  IRQ_EXT_BASE = 8'h10;

    typedef struct packed {
        logic [IRQ_LVL_W-1:0]  level;
        logic                  bk;
        logic [IRQ_SLOT_W-1:0] slot;
    } samp_t;

    typedef struct packed {
        logic                  valid;
        logic                  bk;
        logic [IRQ_SLOT_W-1:0] slot;
        logic [IRQ_TT_W-1:0]   tt;
    } sel_t;
endpackage

// File: rtl/irq_sample.sv
module irq_sample
    import irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRQ_LVL_W-1:0]  irl_pin,
    input  logic                  bkpt_req,
    input  logic [IRQ_SLOT_W-1:0] bkpt_slot,
    output samp_t                 samp_q
);
    samp_t samp_d;

    always_comb begin
        samp_d       = '0;
        samp_d.level = irl_pin;
        samp_d.bk    = bkpt_req;
        samp_d.slot  = bkpt_slot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= samp_d;
    end

    // R2
    sample_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> samp_q.level == $past(irl_pin));
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_pkg::*;
#(
    parameter logic [IRQ_TT_W-1:0] BKPT_TT = 8'h0B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  samp_t                samp_q,
    input  logic                 psr_et,
    input  logic [IRQ_LVL_W-1:0] psr_pil,
    output sel_t                 sel_q
);
    sel_t sel_d;
    logic ext_ok;

    always_comb begin
        ext_ok = (samp_q.level != '0) &&
                 ((samp_q.level == IRQ_NMI) || (samp_q.level > psr_pil));
        sel_d = '0;
        if (psr_et) begin
            if (samp_q.bk) begin
                sel_d.valid = 1'b1;
                sel_d.bk    = 1'b1;
                sel_d.slot  = samp_q.slot;
                sel_d.tt    = BKPT_TT;
            end else if (ext_ok) begin
                sel_d.valid = 1'b1;
                sel_d.tt    = IRQ_EXT_BASE + {{(IRQ_TT_W-IRQ_LVL_W){1'b0}}, samp_q.level};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    // R3
    sel_needs_et_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q.valid |-> $past(psr_et));
    // R4
    sel_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q.valid && !sel_q.bk) |->
            ($past(samp_q.level) == IRQ_NMI || $past(samp_q.level) > $past(psr_pil)));
endmodule

// File: rtl/irq_post.sv
module irq_post
    import irq_pkg::*;
#(
    parameter int SLOTS = IRQ_SLOTS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sel_t                  sel_q,
    input  logic [SLOTS-1:0]      e0_valid,
    output logic                  exc_strobe,
    output logic [IRQ_SLOT_W-1:0] exc_slot,
    output logic [IRQ_TT_W-1:0]   exc_tt
);
    logic [IRQ_SLOT_W-1:0] last_slot;
    logic                  any_valid;
    logic                  bk_hit;

    always_comb begin
        last_slot = '0;
        any_valid = 1'b0;
        bk_hit    = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (e0_valid[i]) begin
                last_slot = i[IRQ_SLOT_W-1:0];
                any_valid = 1'b1;
            end
            if (e0_valid[i] && (sel_q.slot == i[IRQ_SLOT_W-1:0])) bk_hit = 1'b1;
        end
    end

    always_comb begin
        exc_strobe = 1'b0;
        exc_slot   = '0;
        exc_tt     = '0;
        if (sel_q.valid) begin
            if (sel_q.bk && bk_hit) begin
                exc_strobe = 1'b1;
                exc_slot   = sel_q.slot;
                exc_tt     = sel_q.tt;
            end else if (!sel_q.bk && any_valid) begin
                exc_strobe = 1'b1;
                exc_slot   = last_slot;
                exc_tt     = sel_q.tt;
            end
        end
    end

    // R7
    ext_slot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_strobe && !sel_q.bk) |-> (e0_valid >> exc_slot) == 1);
    // R8
    bk_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_strobe && sel_q.bk) |-> e0_valid[exc_slot]);
endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_pkg::*;
#(
    parameter logic [IRQ_TT_W-1:0] BKPT_TT = 8'h0B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRQ_LVL_W-1:0]  irl_pin,
    input  logic                  bkpt_req,
    input  logic [IRQ_SLOT_W-1:0] bkpt_slot,
    input  logic                  psr_et,
    input  logic [IRQ_LVL_W-1:0]  psr_pil,
    input  logic [IRQ_SLOTS-1:0]  e0_valid,
    output logic                  exc_strobe,
    output logic [IRQ_SLOT_W-1:0] exc_slot,
    output logic [IRQ_TT_W-1:0]   exc_tt
);
    samp_t samp_q;
    sel_t  sel_q;

    irq_sample u_sample (
        .clk(clk), .rst_n(rst_n), .irl_pin(irl_pin),
        .bkpt_req(bkpt_req), .bkpt_slot(bkpt_slot), .samp_q(samp_q)
    );

    irq_select #(.BKPT_TT(BKPT_TT)) u_select (
        .clk(clk), .rst_n(rst_n), .samp_q(samp_q),
        .psr_et(psr_et), .psr_pil(psr_pil), .sel_q(sel_q)
    );

    irq_post #(.SLOTS(IRQ_SLOTS)) u_post (
        .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .e0_valid(e0_valid),
        .exc_strobe(exc_strobe), .exc_slot(exc_slot), .exc_tt(exc_tt)
    );

    // R9
    strobe_has_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_strobe |-> (e0_valid != '0));
    // R1
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_strobe |-> (exc_slot == '0 && exc_tt == '0));
    // R6
    tt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_strobe |-> (exc_tt == BKPT_TT || (exc_tt > 8'h10 && exc_tt <= 8'h1F)));
endmodule

// File: tb/sim_irq_accept.sv
module sim_irq_accept;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irl_pin = '0;
    logic       bkpt_req = 1'b0;
    logic [1:0] bkpt_slot = '0;
    logic       psr_et = 1'b0;
    logic [3:0] psr_pil = '0;
    logic [2:0] e0_valid = '0;
    logic       exc_strobe;
    logic [1:0] exc_slot;
    logic [7:0] exc_tt;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    irq_accept u0 (
        .clk(clk), .rst_n(rst_n), .irl_pin(irl_pin), .bkpt_req(bkpt_req),
        .bkpt_slot(bkpt_slot), .psr_et(psr_et), .psr_pil(psr_pil),
        .e0_valid(e0_valid), .exc_strobe(exc_strobe), .exc_slot(exc_slot),
        .exc_tt(exc_tt)
    );

    // reference model: two-entry history of sampled inputs
    int s_lvl = 0, s_bk = 0, s_slot = 0;
    int m_valid = 0, m_bk = 0, m_slot = 0, m_tt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            s_lvl = 0; s_bk = 0; s_slot = 0;
            m_valid = 0; m_bk = 0; m_slot = 0; m_tt = 0;
        end else begin
            m_valid = 0; m_bk = 0; m_slot = 0; m_tt = 0;
            if (psr_et) begin
                if (s_bk != 0) begin
                    m_valid = 1; m_bk = 1; m_slot = s_slot; m_tt = 'h0B;
                end else if (s_lvl != 0 && (s_lvl == 15 || s_lvl > psr_pil)) begin
                    m_valid = 1; m_tt = 'h10 + s_lvl;
                end
            end
            s_lvl = irl_pin; s_bk = bkpt_req; s_slot = bkpt_slot;
        end
    end

    task automatic compare();
        int es = 0, esl = 0, ett = 0;
        if (m_valid != 0) begin
            if (m_bk != 0) begin
                if (m_slot < 3 && e0_valid[m_slot]) begin es = 1; esl = m_slot; ett = m_tt; end
            end else if (e0_valid != 0) begin
                es = 1; ett = m_tt;
                for (int i = 0; i < 3; i++) if (e0_valid[i]) esl = i;
            end
        end
        checks++;
        if (exc_strobe !== es[0] || exc_slot !== esl[1:0] || exc_tt !== ett[7:0]) begin
            errors++;
            $display("FAIL %s: got strobe=%0d slot=%0d tt=%h expected strobe=%0d slot=%0d tt=%h",
                     tag, exc_strobe, exc_slot, exc_tt, es, esl, ett);
        end
    endtask

    always @(negedge clk) if (!done) compare();

    task automatic direct(input bit cond, input string t);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: got strobe=%0d slot=%0d tt=%h (directed)", t, exc_strobe, exc_slot, exc_tt);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                // R1: reset with a live request
                tag = "R1"; irl_pin = 4'd5; psr_et = 1; e0_valid = 3'b111;
                step(3);
                direct(exc_strobe == 0, "R1");
                rst_n = 1;
                step(1);
                direct(exc_strobe == 0, "R1");
                irl_pin = 0; step(3);

                // R2: latency of two edges
                tag = "R2"; psr_pil = 0; irl_pin = 4'd7;
                step(1); direct(exc_strobe == 0, "R2");
                step(1); direct(exc_strobe == 1 && exc_tt == 8'h17 && exc_slot == 2, "R2");
                irl_pin = 0; step(3);

                // R3: traps disabled
                tag = "R3"; psr_et = 0; irl_pin = 4'd15; bkpt_req = 1; step(4);
                direct(exc_strobe == 0, "R3");
                bkpt_req = 0; irl_pin = 0; psr_et = 1; step(3);

                // R4: compare against PIL
                tag = "R4"; psr_pil = 9; irl_pin = 9; step(3);
                direct(exc_strobe == 0, "R4");
                irl_pin = 10; step(3);
                direct(exc_strobe == 1 && exc_tt == 8'h1A, "R4");
                psr_pil = 0; irl_pin = 0; step(3);

                // R5: non-maskable level
                tag = "R5"; psr_pil = 15; irl_pin = 14; step(3);
                direct(exc_strobe == 0, "R5");
                irl_pin = 15; step(3);
                direct(exc_strobe == 1 && exc_tt == 8'h1F, "R5");
                psr_pil = 0; irl_pin = 0; step(3);

                // R6 / R7: trap type and youngest valid slot
                tag = "R7"; irl_pin = 3; e0_valid = 3'b001; step(3);
                direct(exc_slot == 0 && exc_tt == 8'h13, "R6");
                e0_valid = 3'b011; step(1); direct(exc_slot == 1, "R7");
                e0_valid = 3'b101; step(1); direct(exc_slot == 2, "R7");
                e0_valid = 3'b100; step(1); direct(exc_slot == 2, "R7");
                irl_pin = 0; e0_valid = 3'b111; step(3);

                // R8: breakpoint wins, charged to its own slot
                tag = "R8"; irl_pin = 12; bkpt_req = 1; bkpt_slot = 1; step(3);
                direct(exc_strobe == 1 && exc_slot == 1 && exc_tt == 8'h0B, "R8");
                bkpt_slot = 2; e0_valid = 3'b011; step(3);
                direct(exc_strobe == 0, "R8");
                e0_valid = 3'b111; step(1);
                direct(exc_strobe == 1 && exc_slot == 2, "R8");
                bkpt_slot = 3; step(3);
                direct(exc_strobe == 0, "R8");
                bkpt_req = 0; bkpt_slot = 0; irl_pin = 0; step(3);

                // R9: wait for a valid instruction
                tag = "R9"; e0_valid = 0; irl_pin = 8; step(5);
                direct(exc_strobe == 0, "R9");
                e0_valid = 3'b010; step(1);
                direct(exc_strobe == 1 && exc_slot == 1 && exc_tt == 8'h18, "R9");
                irl_pin = 0; e0_valid = 0; step(3);

                // R10: dropped pulse and raised PIL are lost
                tag = "R10"; irl_pin = 6; step(1); irl_pin = 0; step(3);
                e0_valid = 3'b111; step(2);
                direct(exc_strobe == 0, "R10");
                e0_valid = 0; irl_pin = 4; step(3);
                psr_pil = 5; step(2); e0_valid = 3'b001; step(1);
                direct(exc_strobe == 0, "R10");
                irl_pin = 0; psr_pil = 0; step(2);
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule